// File: doc/BRIEF.md
# Two-Bank Clock Register and User Memory Map

This block is the register front end of a battery-backed clock. A 7-bit byte address is decoded against one of two banks. Bit 4 of the control byte at 0Ah picks the bank. The lower half of the address space (00h–3Fh) never changes: fourteen clock and control bytes, then 50 bytes of user memory. In bank 0 the upper half (40h–7Fh) is 64 more bytes of user memory. In bank 1 those bytes are hidden but kept, and the same addresses show extended registers instead:
- a read-only 64-bit identification number,
- a century byte,
- two extended control bytes,
- a pointer and data port pair that reaches 128 more bytes of user memory.

All 242 user bytes can be wiped by an active-low clear input. The clear input only works when an enable bit in the second extended control byte is set. The wipe runs one byte per clock. While it runs, the whole bus is stalled. The block only stores the clock bytes; it does not count time.

Top module: `rtc_bank_map`

## Requirements
- R1: After a synchronous active-low reset:
  - `rdata` is 00h and `busy` is 0.
  - Bank 0 is selected.
  - The century byte reads 20h.
  - The extended pointer reads 00h.
  - Both extended control bytes read 00h.
- R2: Bit 4 of the control byte at 0Ah selects the bank: 0 gives bank 0 and 1 gives bank 1.
- R3: Addresses 00h–3Fh behave the same in both banks. Addresses 00h–0Dh are read/write clock and control bytes. Addresses 0Eh–3Fh are 50 read/write user bytes.
- R4: In bank 0, addresses 40h–7Fh are 64 read/write user bytes. Their contents survive any time spent in bank 1.
- R5: In bank 1, addresses 40h–47h return the identification number, least significant byte at 40h. Writes to these addresses have no effect.
- R6: In bank 1, address 48h is the read/write century byte. Addresses 4Ah and 4Bh are read/write extended control bytes.
- R7: In bank 1, addresses 49h, 4Ch–4Fh, 51h–52h and 54h–7Fh read 00h. Writes to them change nothing.
- R8: Bank 1 reaches the 128-byte extended user memory through two addresses:
  - Address 50h holds a 7-bit pointer. A write drops bit 7, and a read returns bit 7 as 0.
  - Address 53h reads or writes the byte the pointer names. Each accepted access at 53h then advances the pointer by one, wrapping from 7Fh to 00h.
- R9: Bus timing:
  - A read accepted at a clock edge puts its data on `rdata` after that edge.
  - `rdata` holds until the next accepted read.
  - When `wr_en` and `rd_en` are both high, only the write is done.
- R10: A clear sweep starts when all of these hold at a clock edge: bit 3 of 4Bh is 1, `clr_n` is low, and the block is idle.
  - `busy` then rises after that edge and stays high for exactly 242 cycles.
  - Afterwards all 242 user bytes read 00h.
  - Clock bytes, extended registers and the pointer keep their values.
- R11: While bit 3 of 4Bh is 0, `clr_n` has no effect on `busy` or on memory contents.
- R12: While `busy` is high, no read or write is performed: `rdata` and all stored state keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| clr_n | input | 1 | Active-low user memory clear request |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Clear sweep in progress; bus accesses are not performed |

## Verification
The hardest state to reach from the ports is an access that arrives in the middle of a clear sweep. Such an access has to be dropped without disturbing either the sweep or any register. The bench enables clearing through the bank-1 control byte and pulses `clr_n` for one cycle. It then counts the busy cycles at every falling edge. Part-way through, it issues a write to a clock byte and later a read, both timed against that count. After the sweep it checks that the written byte kept its old value and that `rdata` did not move. Before any of this, the bench fills every bank-0 address, the extended memory and the hidden upper bytes with arithmetic patterns. The zeroes left by the sweep, and the values that must survive it, can then be told apart.

// File: rtl/rtc_map_pkg.sv
// Package: shared constants and the region type for the two-bank register map.
// Assumes a 7-bit byte address and byte-wide data.
package rtc_map_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int CLK_BYTES  = 14;
    localparam int LOW_RAM    = 50;
    localparam int HIGH_RAM   = 64;
    localparam int EXT_RAM    = 128;
    localparam int USER_BYTES = LOW_RAM + HIGH_RAM + EXT_RAM;
    localparam int RAM_AW     = $clog2(USER_BYTES);
    localparam int PTR_W      = $clog2(EXT_RAM);
    localparam int BANK_BIT   = 4;
    localparam int CLR_EN_BIT = 3;

    localparam logic [ADDR_W-1:0] CTRLA_ADDR   = 7'h0A;
    localparam logic [ADDR_W-1:0] UPPER_BASE   = 7'h40;
    localparam logic [ADDR_W-1:0] CENTURY_ADDR = 7'h48;
    localparam logic [ADDR_W-1:0] EXTA_ADDR    = 7'h4A;
    localparam logic [ADDR_W-1:0] EXTB_ADDR    = 7'h4B;
    localparam logic [ADDR_W-1:0] XPTR_ADDR    = 7'h50;
    localparam logic [ADDR_W-1:0] XDATA_ADDR   = 7'h53;

    typedef enum logic [3:0] {
        RG_NONE, RG_CLK, RG_RAM, RG_SERIAL, RG_CENTURY,
        RG_EXTA, RG_EXTB, RG_XPTR, RG_XDATA
    } region_e;
endpackage

// File: rtl/rtc_addr_decode.sv
// Module: rtc_addr_decode
// Maps an address and the bank bit to a region and an index inside it.
// Assumes: bank-0 user bytes are packed so that index = address - 14 for 0Eh..7Fh.
module rtc_addr_decode
    import rtc_map_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IDW = RAM_AW
) (
    input  logic [AW-1:0]  addr,
    input  logic           bank,
    output region_e        region,
    output logic [IDW-1:0] idx
);
    // Purpose: pure address decode, lower half fixed and upper half bank-dependent.
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (addr < AW'(CLK_BYTES)) begin
            region = RG_CLK;
            idx    = IDW'(addr);
        end else if (addr < UPPER_BASE || !bank) begin
            region = RG_RAM;
            idx    = IDW'(addr) - IDW'(CLK_BYTES);
        end else if (addr[AW-1:3] == UPPER_BASE[AW-1:3]) begin
            region = RG_SERIAL;
            idx    = IDW'(addr[2:0]);
        end else begin
            case (addr)
                CENTURY_ADDR: region = RG_CENTURY;
                EXTA_ADDR:    region = RG_EXTA;
                EXTB_ADDR:    region = RG_EXTB;
                XPTR_ADDR:    region = RG_XPTR;
                XDATA_ADDR:   region = RG_XDATA;
                default:      region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/rtc_user_ram.sv
// Module: rtc_user_ram
// Single-port user byte store with a one-byte-per-clock clear sequencer.
// Assumes: the caller never writes while busy; addresses are always < DEPTH.
module rtc_user_ram #(
    parameter int DEPTH = 242,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          clr_req,
    output logic          busy
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] sweep;

    // Purpose: run the clear sweep from index 0 to DEPTH-1, then drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sweep <= '0;
        end else if (busy) begin
            if (sweep == AW'(DEPTH - 1)) busy <= 1'b0;
            sweep <= sweep + 1'b1;
        end else if (clr_req) begin
            busy  <= 1'b1;
            sweep <= '0;
        end
    end

    // Purpose: store bytes; the sweep owns the write port while busy.
    always_ff @(posedge clk) begin
        if (busy) mem[sweep] <= '0;
        else if (we) mem[addr] <= wdata;
    end

    // Purpose: asynchronous read; the top registers the result.
    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_ctrl_regs.sv
// Module: rtc_ctrl_regs
// Clock/control bytes, century byte, extended control bytes and extended pointer.
// Assumes: writes and data-port accesses arrive only when the bus is not stalled.
module rtc_ctrl_regs
    import rtc_map_pkg::*;
#(
    parameter int          DW     = DATA_W,
    parameter int          IDW    = RAM_AW,
    parameter int          PW     = PTR_W,
    parameter logic [63:0] SERIAL = 64'hA5C3_0F1E_7B29_D486
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  region_e        region,
    input  logic [IDW-1:0] idx,
    input  logic [DW-1:0]  wdata,
    input  logic           xacc,
    output logic [DW-1:0]  rdata,
    output logic           bank,
    output logic           clr_en,
    output logic [PW-1:0]  xptr
);
    logic [DW-1:0] clk_q [CLK_BYTES];
    logic [DW-1:0] century_q, exta_q, extb_q;

    // Purpose: register writes, with reset values for every control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CLK_BYTES; i++) clk_q[i] <= '0;
            century_q <= 8'h20;
            exta_q    <= '0;
            extb_q    <= '0;
        end else if (we) begin
            case (region)
                RG_CLK:     clk_q[idx[3:0]] <= wdata;
                RG_CENTURY: century_q <= wdata;
                RG_EXTA:    exta_q <= wdata;
                RG_EXTB:    extb_q <= wdata;
                default:    ;
            endcase
        end
    end

    // Purpose: extended pointer, loaded by a write at its address, bumped per data access.
    always_ff @(posedge clk) begin
        if (!rst_n) xptr <= '0;
        else if (we && region == RG_XPTR) xptr <= wdata[PW-1:0];
        else if (xacc) xptr <= xptr + 1'b1;
    end

    // Purpose: read mux for register regions; everything else reads zero.
    always_comb begin
        case (region)
            RG_CLK:     rdata = clk_q[idx[3:0]];
            RG_SERIAL:  rdata = DW'(SERIAL >> {idx[2:0], 3'b000});
            RG_CENTURY: rdata = century_q;
            RG_EXTA:    rdata = exta_q;
            RG_EXTB:    rdata = extb_q;
            RG_XPTR:    rdata = DW'(xptr);
            default:    rdata = '0;
        endcase
    end

    assign bank   = clk_q[CTRLA_ADDR[3:0]][BANK_BIT];
    assign clr_en = extb_q[CLR_EN_BIT];
endmodule

// File: rtl/rtc_bank_map.sv
// Module: rtc_bank_map (top)
// Two-bank register and user memory map with gated clear and a stalled bus while clearing.
// Assumes: one access per cycle; a write wins over a read in the same cycle;
// an access presented while busy is dropped and must be repeated by the host.
module rtc_bank_map
    import rtc_map_pkg::*;
#(
    parameter int          AW     = ADDR_W,
    parameter int          DW     = DATA_W,
    parameter logic [63:0] SERIAL = 64'hA5C3_0F1E_7B29_D486
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          clr_n,
    output logic [DW-1:0] rdata,
    output logic          busy
);
    localparam int EXT_BASE = LOW_RAM + HIGH_RAM;

    region_e            region;
    logic [RAM_AW-1:0]  idx, ram_addr;
    logic [DW-1:0]      reg_rdata, ram_rdata;
    logic               bank, clr_en, acc_wr, acc_rd, is_mem;
    logic [PTR_W-1:0]   xptr;

    assign acc_wr   = wr_en && !busy;
    assign acc_rd   = rd_en && !wr_en && !busy;
    assign is_mem   = (region == RG_RAM) || (region == RG_XDATA);
    assign ram_addr = (region == RG_XDATA) ? RAM_AW'(EXT_BASE) + RAM_AW'(xptr) : idx;

    rtc_addr_decode #(.AW(AW), .IDW(RAM_AW)) u_dec (
        .addr(addr), .bank(bank), .region(region), .idx(idx)
    );

    rtc_ctrl_regs #(.DW(DW), .IDW(RAM_AW), .PW(PTR_W), .SERIAL(SERIAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(acc_wr), .region(region), .idx(idx),
        .wdata(wdata), .xacc((acc_wr || acc_rd) && region == RG_XDATA),
        .rdata(reg_rdata), .bank(bank), .clr_en(clr_en), .xptr(xptr)
    );

    rtc_user_ram #(.DEPTH(USER_BYTES), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(acc_wr && is_mem), .addr(ram_addr),
        .wdata(wdata), .rdata(ram_rdata),
        .clr_req(clr_en && !clr_n), .busy(busy)
    );

    // Purpose: capture read data on an accepted read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (acc_rd) rdata <= is_mem ? ram_rdata : reg_rdata;
    end
endmodule

// File: rtl/rtc_bank_map_chk.sv
// Module: rtc_bank_map_chk
// Property checker bound into rtc_bank_map; observes ports and a few internal controls.
module rtc_bank_map_chk #(
    parameter int          AW     = 7,
    parameter int          DW     = 8,
    parameter logic [63:0] SERIAL = 64'h0,
    parameter int          DEPTH  = 242,
    parameter int          PW     = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          clr_n,
    input logic [DW-1:0] rdata,
    input logic          busy,
    input logic          bank,
    input logic          clr_en,
    input logic [PW-1:0] xptr
);
    logic [15:0] busy_cnt;

    // Purpose: count busy cycles so the sweep length is checked without a long $past.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else busy_cnt <= busy_cnt + 1'b1;
    end

    a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!clr_n && clr_en));

    a_r10_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_cnt) == 16'(DEPTH - 1));

    a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !busy) |=> !busy);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en || busy) |=> $stable(rdata));

    a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rdata) && $stable(xptr));

    a_r5_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !busy && bank && addr[AW-1:3] == 4'h8)
        |=> rdata == DW'(SERIAL >> {$past(addr[2:0]), 3'b000}));

    a_r7_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !busy && bank && (addr == 7'h49 || addr >= 7'h54))
        |=> rdata == '0);

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !busy && bank && addr == 7'h53)
        |=> xptr == $past(xptr) + 1'b1);
endmodule

bind rtc_bank_map rtc_bank_map_chk #(
    .AW(AW), .DW(DW), .SERIAL(SERIAL), .DEPTH(rtc_map_pkg::USER_BYTES), .PW(rtc_map_pkg::PTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .clr_n(clr_n), .rdata(rdata), .busy(busy), .bank(bank), .clr_en(clr_en), .xptr(xptr)
);

// File: tb/sim_rtc_bank_map.sv
// Bench: sweeps every address in both banks, the extended memory and the clear sequence.
module sim_rtc_bank_map;
    localparam logic [63:0] SER = 64'hA5C3_0F1E_7B29_D486;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, clr_n = 1'b1;
    logic [7:0] rdata;
    logic       busy;
    int         total = 0, fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_bank_map u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .clr_n(clr_n), .rdata(rdata), .busy(busy)
    );

    function automatic logic [7:0] pat(input int a);
        logic [7:0] v;
        v = 8'(a * 7 + 3);
        if (a == 'h0A) v = v & 8'hEF;
        return v;
    endfunction

    function automatic logic [7:0] xpat(input int i);
        return 8'(i * 13) ^ 8'h5A;
    endfunction

    function automatic bit unmapped(input int a);
        return a == 'h49 || (a >= 'h4C && a <= 'h4F) || a == 'h51 || a == 'h52 || a >= 'h54;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rchk(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 busy", {7'b0, busy}, 8'h00);
        // R3 R4: fill every bank-0 address, then read back (also R2: bank 0 after reset)
        for (int a = 0; a < 128; a++) wr(7'(a), pat(a));
        for (int a = 0; a < 128; a++) rchk("R3/R4 bank0 sweep", 7'(a), pat(a));
        // R2: select bank 1
        wr(7'h0A, 8'h10);
        for (int a = 0; a < 64; a++) rchk("R3 low half in bank1", 7'(a), a == 'h0A ? 8'h10 : pat(a));
        // R1 R5 R6 R7 R8: upper half of bank 1 (skip data port)
        for (int a = 'h40; a < 'h80; a++) begin
            if (a != 'h53) begin
                if (a < 'h48) rchk("R5 serial", 7'(a), 8'(SER >> (8 * (a - 'h40))));
                else if (a == 'h48) rchk("R1 century reset", 7'(a), 8'h20);
                else rchk("R1/R7 reset upper", 7'(a), 8'h00);
            end
        end
        // R5 R7: writes to read-only and unmapped locations have no effect
        for (int a = 'h40; a < 'h80; a++) if (a < 'h48 || unmapped(a)) wr(7'(a), 8'hFF);
        for (int a = 'h40; a < 'h80; a++) begin
            if (a < 'h48) rchk("R5 serial after write", 7'(a), 8'(SER >> (8 * (a - 'h40))));
            else if (unmapped(a)) rchk("R7 unmapped after write", 7'(a), 8'h00);
        end
        // R6: writable extended bytes
        wr(7'h48, 8'h19); wr(7'h4A, 8'h3C);
        rchk("R6 century", 7'h48, 8'h19);
        rchk("R6 ext A", 7'h4A, 8'h3C);
        // R8: extended memory through the pointer and data port
        wr(7'h50, 8'h00);
        for (int i = 0; i < 128; i++) wr(7'h53, xpat(i));
        rchk("R8 pointer wrap", 7'h50, 8'h00);
        for (int i = 0; i < 128; i++) rchk("R8 ext read", 7'h53, xpat(i));
        wr(7'h50, 8'hF5);
        rchk("R8 pointer bit7 dropped", 7'h50, 8'h75);
        rchk("R8 ext at 75h", 7'h53, xpat('h75));
        rchk("R8 pointer advanced", 7'h50, 8'h76);
        // R4 R2: back to bank 0, hidden bytes intact
        wr(7'h0A, 8'h00);
        for (int a = 'h40; a < 'h80; a++) rchk("R4 upper preserved", 7'(a), pat(a));
        // R9: simultaneous read and write performs the write only
        @(negedge clk);
        addr = 7'h20; wdata = 8'hC7; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 write wins, rdata held", rdata, pat('h7F));
        rchk("R9 write done", 7'h20, 8'hC7);
        // R11: clear input ignored while disabled
        @(negedge clk); clr_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R11 busy stays low", {7'b0, busy}, 8'h00);
        end
        clr_n = 1'b1;
        rchk("R11 low ram intact", 7'h0E, pat('h0E));
        rchk("R11 upper ram intact", 7'h41, pat('h41));
        // R10 R12: enable and run a clear sweep with accesses during it
        wr(7'h0A, 8'h10);
        wr(7'h4B, 8'h08);
        rd(7'h4B, d);
        chk("R6 ext B", d, 8'h08);
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        chk("R10 busy rises", {7'b0, busy}, 8'h01);
        cnt = 0;
        while (busy === 1'b1 && cnt < 1000) begin
            cnt++;
            if (cnt == 3) begin addr = 7'h01; wdata = 8'hAA; wr_en = 1'b1; end
            if (cnt == 4) wr_en = 1'b0;
            if (cnt == 10) begin addr = 7'h01; rd_en = 1'b1; end
            if (cnt == 11) begin rd_en = 1'b0; chk("R12 rdata held", rdata, 8'h08); end
            @(negedge clk);
        end
        chk("R10 busy length lo", 8'(cnt), 8'(242));
        chk("R10 busy length hi", 8'(cnt >> 8), 8'(242 >> 8));
        rchk("R12 write dropped", 7'h01, pat(1));
        rchk("R10 ctrl kept", 7'h4B, 8'h08);
        rchk("R10 century kept", 7'h48, 8'h19);
        rchk("R10 pointer kept", 7'h50, 8'h76);
        rchk("R10 ctrl A kept", 7'h0A, 8'h10);
        for (int a = 'h0E; a < 'h40; a++) rchk("R10 low ram cleared", 7'(a), 8'h00);
        wr(7'h50, 8'h00);
        for (int i = 0; i < 128; i++) rchk("R10 ext ram cleared", 7'h53, 8'h00);
        wr(7'h0A, 8'h00);
        for (int a = 'h40; a < 'h80; a++) rchk("R10 upper ram cleared", 7'(a), 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule